// File: doc/BRIEF.md
# Companion GPIO and Control Register Bank

This block is a small memory-mapped peripheral that sits beside a host processor. It holds a set of 16-bit control registers: operating mode, card detect, a read-only card status word, power control, card control, and the interrupt request, mask and status words. It also owns sixteen general-purpose lines, each with a direction bit and a level bit. The host reaches the registers through a plain synchronous bus. The bus has a byte address, a write enable and 16-bit write data, and it returns read data combinationally for the address on the bus.

The sixteen output lines always show the stored level gated by direction. They are recomputed only when the host writes the direction word or the level word. Each recompute raises a one-cycle change strobe on exactly the lines whose value moved. Sixteen input lines, each qualified by its own strobe, can set or clear stored level bits directly. They do not move the output lines until the host next writes direction or level. A write to the power word with bit 7 set also forces bits 15 and 6 high.

Top module: `sidechip_gpio_regs`

## Requirements
- R1: After reset, the card status word at offset 0x08 reads 0x0002. Every other register reads 0x0000, and both `line_out` and `line_chg` are zero.
- R2: The mode (0x00), card detect (0x04), card control (0x10), interrupt request (0x14), interrupt mask (0x18) and interrupt status (0x1C) words store the written data and return it on a read.
- R3: A write to the power word at 0x0C stores the data. When bit 7 of the data is 1, the stored word also has bits 15 and 6 set (the data ORed with 0x8040).
- R4: A write to offset 0x08 is ignored, and the card status word keeps reading 0x0002.
- R5: A write to offset 0x24 or 0x28 stores the data ANDed with the direction word in force before that write. A read of either offset returns the stored level.
- R6: The direction word at offset 0x20 stores the written data and returns it on a read.
- R7: On the clock edge that takes a write to 0x20, 0x24 or 0x28, `line_out` becomes the new level ANDed with the new direction.
- R8: `line_chg` is high for one cycle after such a write, on exactly the bits where `line_out` changed. It is zero in every other cycle.
- R9: When bit i of `line_in_stb` is 1, level bit i takes the value of `line_in_val[i]`. Direction does not gate this update. `line_out` and `line_chg` do not respond to it.
- R10: When a bus write to 0x24 or 0x28 falls in the same cycle as input strobes, the bus value sets the level and the strobes are dropped.
- R11: A read of any address outside the listed offsets, including unaligned addresses, returns zero. A write to such an address changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| line_in_stb | input | 16 | Per-line strobe; a 1 on bit i updates level bit i this cycle |
| line_in_val | input | 16 | Value taken by strobed level bits |
| line_out | output | 16 | Effective output level (level AND direction) |
| line_chg | output | 16 | One-cycle mask of the output bits that toggled |

## Verification
A bad direction or level bit shows up at the read port on the next access to 0x20, 0x24 or 0x28. It reaches `line_out` on the first clock after the next write to either word. A stale copy of the previous effective level gives a wrong `line_chg` mask on the very update that follows. This matters most where a write leaves the outputs unchanged, and where narrowing the direction word drops lines that were high. The reference model is compared with the read port, `line_out` and `line_chg` on every clock. A corrupted register or a missed side effect is therefore reported in the cycle after the access that exposes it.

// File: rtl/sidechip_pkg.sv
// Package: shared constants for the companion register bank.
// Assumes a 16-bit register word and a byte-addressed bus.
package sidechip_pkg;
    localparam int REG_W    = 16;
    localparam int N_LINES  = 16;

    localparam int OFS_MODE  = 'h00;
    localparam int OFS_CDET  = 'h04;
    localparam int OFS_CSTAT = 'h08;
    localparam int OFS_PWR   = 'h0C;
    localparam int OFS_CCTL  = 'h10;
    localparam int OFS_IREQ  = 'h14;
    localparam int OFS_IMSK  = 'h18;
    localparam int OFS_ISTS  = 'h1C;
    localparam int OFS_DIR   = 'h20;
    localparam int OFS_LVLW  = 'h24;
    localparam int OFS_LVLR  = 'h28;

    // Plain storage words: written and read back unchanged.
    localparam int N_PLAIN = 6;
    localparam int PLAIN_OFS [N_PLAIN] = '{OFS_MODE, OFS_CDET, OFS_CCTL,
                                          OFS_IREQ, OFS_IMSK, OFS_ISTS};

    localparam logic [REG_W-1:0] CSTAT_VAL = 16'h0002;
    localparam logic [REG_W-1:0] PWR_FORCE = 16'h8040;
    localparam int               PWR_TRIG  = 7;

    // Apply the power-word side effect to a write value.
    function automatic logic [REG_W-1:0] pwr_fix(input logic [REG_W-1:0] v);
        return v[PWR_TRIG] ? (v | PWR_FORCE) : v;
    endfunction
endpackage

// File: rtl/sidechip_ctrl_regs.sv
// Module: control register file (mode, card, power, interrupt words).
// Assumes: decode on the full byte address; read data is zero on a miss;
// the card status word is a constant and ignores writes.
module sidechip_ctrl_regs
    import sidechip_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata
);
    logic [REG_W-1:0]   plain_q [N_PLAIN];
    logic [N_PLAIN-1:0] plain_hit;
    logic [REG_W-1:0]   pwr_q;
    logic               pwr_hit;
    logic               cstat_hit;

    assign pwr_hit   = (addr == ADDR_W'(OFS_PWR));
    assign cstat_hit = (addr == ADDR_W'(OFS_CSTAT));

    for (genvar gi = 0; gi < N_PLAIN; gi++) begin : g_plain
        assign plain_hit[gi] = (addr == ADDR_W'(PLAIN_OFS[gi]));
        // Store one plain word on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                plain_q[gi] <= '0;
            else if (we && plain_hit[gi])
                plain_q[gi] <= wdata;
        end
    end

    // Store the power word with its forced bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwr_q <= '0;
        else if (we && pwr_hit)
            pwr_q <= pwr_fix(wdata);
    end

    // OR together the read contributions of every hit word.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_PLAIN; i++)
            if (plain_hit[i]) rdata = rdata | plain_q[i];
        if (pwr_hit)   rdata = rdata | pwr_q;
        if (cstat_hit) rdata = rdata | CSTAT_VAL;
    end

    // R3: bit 7 written high forces bits 15 and 6.
    p_power_force_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && pwr_hit && wdata[PWR_TRIG]) |=> (pwr_q[15] && pwr_q[6]));

    // R11: a write elsewhere leaves the power word alone.
    p_power_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && pwr_hit) |=> $stable(pwr_q));
endmodule

// File: rtl/sidechip_line_core.sv
// Module: direction/level storage, output gating and change detection.
// Assumes: outputs are recomputed only on a bus write to direction or
// level; input strobes edit the level silently; bus writes win over strobes.
module sidechip_line_core
    import sidechip_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               we,
    input  logic [REG_W-1:0]   wdata,
    input  logic [N_LINES-1:0] in_stb,
    input  logic [N_LINES-1:0] in_val,
    output logic [REG_W-1:0]   rdata,
    output logic [N_LINES-1:0] out_lvl,
    output logic [N_LINES-1:0] out_chg
);
    logic [N_LINES-1:0] dir_q, lvl_q, out_q, chg_q;
    logic [N_LINES-1:0] dir_nxt, lvl_in, lvl_nxt, eff_nxt;
    logic               dir_hit, lvl_hit, dir_wr, lvl_wr, upd;

    assign dir_hit = (addr == ADDR_W'(OFS_DIR));
    assign lvl_hit = (addr == ADDR_W'(OFS_LVLW)) || (addr == ADDR_W'(OFS_LVLR));
    assign dir_wr  = we && dir_hit;
    assign lvl_wr  = we && lvl_hit;
    assign upd     = dir_wr || lvl_wr;

    // Work out next direction, level and gated output for this cycle.
    always_comb begin
        dir_nxt = dir_wr ? wdata[N_LINES-1:0] : dir_q;
        lvl_in  = (lvl_q & ~in_stb) | (in_val & in_stb);
        lvl_nxt = lvl_wr ? (wdata[N_LINES-1:0] & dir_q) : lvl_in;
        eff_nxt = lvl_nxt & dir_nxt;
    end

    // Hold direction and level, and refresh outputs on an update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            lvl_q <= '0;
            out_q <= '0;
            chg_q <= '0;
        end else begin
            dir_q <= dir_nxt;
            lvl_q <= lvl_nxt;
            if (upd) begin
                out_q <= eff_nxt;
                chg_q <= eff_nxt ^ out_q;
            end else begin
                chg_q <= '0;
            end
        end
    end

    // Return direction or level for a matching read.
    always_comb begin
        rdata = '0;
        if (dir_hit)      rdata = REG_W'(dir_q);
        else if (lvl_hit) rdata = REG_W'(lvl_q);
    end

    assign out_lvl = out_q;
    assign out_chg = chg_q;

    // R7: no output is high on a line that is not an output.
    p_out_in_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q & ~dir_q) == '0);

    // R8: the strobe is silent without a direction or level write.
    p_chg_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> (chg_q == '0));

    // R8: the strobe marks exactly the toggled output bits.
    p_chg_diff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (chg_q == (out_q ^ $past(out_q))));

    // R9: outputs hold while only strobes or other writes arrive.
    p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(out_q));

    // R10: a bus level write overrides strobes and is masked by old direction.
    p_bus_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_wr |=> (lvl_q == ($past(wdata[N_LINES-1:0]) & $past(dir_q))));
endmodule

// File: rtl/sidechip_gpio_regs.sv
// Module: top of the companion register bank. Splits the bus between the
// control register file and the line core and merges their read data.
// Assumes: one access per cycle; read data is combinational on bus_addr.
module sidechip_gpio_regs
    import sidechip_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [N_LINES-1:0] line_in_stb,
    input  logic [N_LINES-1:0] line_in_val,
    output logic [N_LINES-1:0] line_out,
    output logic [N_LINES-1:0] line_chg
);
    logic [REG_W-1:0] ctrl_rd, line_rd;

    sidechip_ctrl_regs #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .we    (bus_we),
        .wdata (bus_wdata),
        .rdata (ctrl_rd)
    );

    sidechip_line_core #(.ADDR_W(ADDR_W)) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .in_stb  (line_in_stb),
        .in_val  (line_in_val),
        .rdata   (line_rd),
        .out_lvl (line_out),
        .out_chg (line_chg)
    );

    // Merge the read data; the two decoders never hit together.
    assign bus_rdata = ctrl_rd | line_rd;

    // R11: an unaligned address always reads zero.
    p_unaligned_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_sidechip_gpio_regs.sv
// Bench: behavioural reference model compared on every clock.
module tb_sidechip_gpio_regs;
    localparam int AW = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] line_in_stb = '0;
    logic [15:0] line_in_val = '0;
    logic [15:0] line_out;
    logic [15:0] line_chg;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    logic [15:0] m_reg [int];
    logic [15:0] m_dir, m_lvl, m_out, m_chg;

    always #2 clk = ~clk;

    sidechip_gpio_regs #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .line_in_stb(line_in_stb), .line_in_val(line_in_val),
        .line_out(line_out), .line_chg(line_chg)
    );

    task automatic model_reset();
        m_reg.delete();
        m_reg['h00] = 0; m_reg['h04] = 0; m_reg['h08] = 16'h0002;
        m_reg['h0C] = 0; m_reg['h10] = 0; m_reg['h14] = 0;
        m_reg['h18] = 0; m_reg['h1C] = 0;
        m_dir = 0; m_lvl = 0; m_out = 0; m_chg = 0;
    endtask

    function automatic logic [15:0] m_read(int a);
        if (a == 'h20) return m_dir;
        if (a == 'h24 || a == 'h28) return m_lvl;
        if (m_reg.exists(a)) return m_reg[a];
        return 16'h0000;
    endfunction

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // One bus cycle: check read data, clock, update model, check outputs.
    task automatic step(string req, int a, bit w, logic [15:0] d,
                        logic [15:0] stb = 16'h0, logic [15:0] v = 16'h0);
        logic [15:0] nl;
        bit ev;
        bus_addr = a[11:0]; bus_we = w; bus_wdata = d;
        line_in_stb = stb; line_in_val = v;
        #1;
        chk(req, "bus_rdata", bus_rdata, m_read(a));
        @(posedge clk);
        nl = (m_lvl & ~stb) | (v & stb);
        ev = 1'b0;
        if (w) begin
            case (a)
                'h20: begin m_dir = d; ev = 1'b1; end
                'h24, 'h28: begin nl = d & m_dir; ev = 1'b1; end
                'h0C: m_reg[a] = d[7] ? (d | 16'h8040) : d;
                'h08: ;
                default: if (m_reg.exists(a)) m_reg[a] = d;
            endcase
        end
        m_lvl = nl;
        if (ev) begin
            m_chg = (m_lvl & m_dir) ^ m_out;
            m_out = m_lvl & m_dir;
        end else begin
            m_chg = 16'h0;
        end
        @(negedge clk);
        bus_we = 1'b0; line_in_stb = '0;
        chk(req, "line_out", line_out, m_out);
        chk(req, "line_chg", line_chg, m_chg);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", 20000);
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values on every register and on the outputs.
        chk("R1", "line_out", line_out, 16'h0);
        chk("R1", "line_chg", line_chg, 16'h0);
        for (int a = 0; a <= 'h28; a += 4) step("R1", a, 1'b0, 16'h0);

        // R2: plain words store and return data.
        step("R2", 'h00, 1'b1, 16'hA5C3);
        step("R2", 'h04, 1'b1, 16'h0101);
        step("R2", 'h10, 1'b1, 16'hFFFF);
        step("R2", 'h14, 1'b1, 16'h1234);
        step("R2", 'h18, 1'b1, 16'h8001);
        step("R2", 'h1C, 1'b1, 16'h7E00);
        foreach (m_reg[k]) step("R2", k, 1'b0, 16'h0);

        // R3: power word side effect, with and without bit 7.
        step("R3", 'h0C, 1'b1, 16'h0081);
        step("R3", 'h0C, 1'b0, 16'h0);
        step("R3", 'h0C, 1'b1, 16'h0012);
        step("R3", 'h0C, 1'b0, 16'h0);

        // R4: card status ignores writes.
        step("R4", 'h08, 1'b1, 16'hFFFF);
        step("R4", 'h08, 1'b0, 16'h0);

        // R11: unmapped and unaligned accesses.
        step("R11", 'h2C, 1'b1, 16'hABCD);
        step("R11", 'h2C, 1'b0, 16'h0);
        step("R11", 'h01, 1'b1, 16'hFFFF);
        step("R11", 'h01, 1'b0, 16'h0);
        step("R11", 'h100, 1'b0, 16'h0);
        step("R11", 'hFFC, 1'b1, 16'h5555);
        step("R11", 'h00, 1'b0, 16'h0);

        // R6, R7: direction then level writes.
        step("R6", 'h20, 1'b1, 16'h00FF);
        step("R6", 'h20, 1'b0, 16'h0);
        step("R7", 'h24, 1'b1, 16'hF0F3);
        step("R5", 'h28, 1'b0, 16'h0);
        step("R5", 'h24, 1'b0, 16'h0);

        // R8: unchanged write gives no strobe; partial change gives a mask.
        step("R8", 'h28, 1'b1, 16'h00F3);
        step("R8", 'h24, 1'b1, 16'h0031);
        step("R8", 'h20, 1'b1, 16'h000F);

        // R9: input strobes edit level silently.
        step("R9", 'h00, 1'b0, 16'h0, 16'h0F00, 16'h0F00);
        step("R9", 'h24, 1'b0, 16'h0, 16'h0001, 16'h0000);
        step("R9", 'h28, 1'b0, 16'h0);
        step("R9", 'h20, 1'b1, 16'hFFFF, 16'h8000, 16'h8000);
        step("R9", 'h24, 1'b0, 16'h0);

        // R10: bus write to level wins over strobes in the same cycle.
        step("R10", 'h20, 1'b1, 16'h0FF0);
        step("R10", 'h24, 1'b1, 16'h1234, 16'hFFFF, 16'hFFFF);
        step("R10", 'h28, 1'b0, 16'h0);
        step("R10", 'h28, 1'b1, 16'hFFFF, 16'h00FF, 16'h0000);
        step("R10", 'h24, 1'b0, 16'h0);

        step("R8", 'h20, 1'b1, 16'h0000);
        step("R8", 'h00, 1'b0, 16'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule